// File: doc/BRIEF.md
# Full-Cycle Serial Signature Compactor

This block condenses the response stream of a circuit under self-test into a short signature. On each enabled clock it takes one response bit and folds it into a shift register with XOR feedback. The feedback also carries a correction term. Because of that term, the register with a constant-zero input walks through every one of its 2^W codes, the all-zero code included, rather than skipping one.

In use, the register is first cleared or seeded. It then compacts the full response sequence, and at the end its contents are compared with a known-good value. A faulty stream lands on the correct code with a probability of about 2^-W. The signature can be read two ways. A parallel output and a combinational equality flag give it at once. An unload request gives it serially, most significant bit first, over W clocks; the folding feedback is switched off during those clocks.

Top module: `full_cycle_sig`

## Requirements
- R1: After the synchronous active-high reset, `sig` is 0000 and `ser_valid` is 0, whatever the other inputs are.
- R2: `clr` high forces `sig` to 0000 at the next edge and ends any unload in progress. It overrides `load`, `unload` and `en`.
- R3: With `clr` low, `load` high puts `seed` into `sig` at the next edge and ends any unload in progress. It overrides `unload` and `en`.
- R4: With `clr`, `load` and `unload` low, no unload running and `en` low, `sig` holds its value and `din` is ignored.
- R5: When folding with `din` held at 0 from 0000, `sig` steps through 0001, 0011, 0111, 1111, 1110, 1101, 1010, 0101, 1011, 0110, 1100, 1001, 0010, 0100, 1000, 0000 and then repeats.
- R6: A fold step (`en` high, nothing of higher priority) shifts `sig` left by one bit. The new bit 0 is old bit 3 XOR old bit 0 XOR `din`, inverted when old bits 2..0 are all zero.
- R7: A one-cycle `unload` pulse arms the unload and leaves `sig` unchanged. On each of the next 4 clocks, `ser_valid` is 1 and `ser_out` presents the bits of `sig` as they stood when the unload was armed, bit 3 first, while `sig` shifts left with 0 filling in and `din` and `en` are ignored. Afterwards `ser_valid` is 0 and `sig` is 0000.
- R8: `match` is 1 exactly when `sig` equals `golden`, in the same cycle.
- R9: An `unload` request made while an unload is already running has no effect: the unload still lasts exactly 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the signature |
| load | input | 1 | Preset the signature from `seed` |
| seed | input | W | Preset value |
| en | input | 1 | Fold `din` into the signature this clock |
| din | input | 1 | Serial response bit |
| unload | input | 1 | Request a serial unload |
| golden | input | W | Known-good signature |
| sig | output | W | Current signature (register) |
| ser_out | output | 1 | Serial unload bit (signature MSB) |
| ser_valid | output | 1 | High while an unload is presenting bits |
| match | output | 1 | `sig` equals `golden` |

## Verification
The bench builds the block with its default width of 4 and feedback taps on bits 3 and 0. With that width, the complete 16-code zero-input cycle, including the wrap through 0000, fits in 16 clocks, and a whole unload of 4 bits can be checked bit by bit. The small width also lets the bench interleave clear, load and repeated unload requests inside one unload, so every priority case is exercised against a scoreboard model.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CLEAR,
    OP_LOAD,
    OP_SHIFT,
    OP_ARM,
    OP_FOLD
  } fcs_op_e;
endpackage

// File: rtl/fcs_fold_next.sv
`timescale 1ns/1ps
module fcs_fold_next #(
  parameter int W = 4,
  parameter logic [W-1:0] TAPS = 4'b1001
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  localparam int LOW = W - 1;

  logic [W-1:0] tapped;
  logic         tap_par;
  logic         low_zero;
  logic         fb;

  // per-bit tap gating
  for (genvar i = 0; i < W; i++) begin : g_tap
    assign tapped[i] = cur[i] & TAPS[i];
  end

  assign tap_par  = ^tapped;
  // closes the cycle through the all-zero code
  assign low_zero = (cur[LOW-1:0] == '0);
  assign fb       = tap_par ^ din ^ low_zero;
  assign nxt      = {cur[W-2:0], fb};
endmodule

// File: rtl/fcs_unload_ctl.sv
`timescale 1ns/1ps
module fcs_unload_ctl
  import fcs_pkg::*;
#(
  parameter int W = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    load,
  input  logic    en,
  input  logic    unload,
  output fcs_op_e op,
  output logic    busy
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] left_q;

  always_comb begin
    if (clr)                 op = OP_CLEAR;
    else if (load)           op = OP_LOAD;
    else if (left_q != '0)   op = OP_SHIFT;
    else if (unload)         op = OP_ARM;
    else if (en)             op = OP_FOLD;
    else                     op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else begin
      case (op)
        OP_CLEAR, OP_LOAD: left_q <= '0;
        OP_SHIFT:          left_q <= left_q - 1'b1;
        OP_ARM:            left_q <= FULL;
        default:           left_q <= left_q;
      endcase
    end
  end

  assign busy = (left_q != '0);

  // R9
  rearm_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr && !load) |=> (left_q == $past(left_q) - 1'b1));

  // R7
  arm_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && unload && !clr && !load) |=> (left_q == FULL));
endmodule

// File: rtl/full_cycle_sig.sv
`timescale 1ns/1ps
module full_cycle_sig
  import fcs_pkg::*;
#(
  parameter int W = 4,
  parameter logic [W-1:0] TAPS = 4'b1001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         en,
  input  logic         din,
  input  logic         unload,
  input  logic [W-1:0] golden,
  output logic [W-1:0] sig,
  output logic         ser_out,
  output logic         ser_valid,
  output logic         match
);
  fcs_op_e      op;
  logic         busy;
  logic [W-1:0] sig_q;
  logic [W-1:0] fold_nxt;

  fcs_unload_ctl #(.W(W)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .load   (load),
    .en     (en),
    .unload (unload),
    .op     (op),
    .busy   (busy)
  );

  fcs_fold_next #(.W(W), .TAPS(TAPS)) u_fold (
    .cur (sig_q),
    .din (din),
    .nxt (fold_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q <= '0;
    end else begin
      case (op)
        OP_CLEAR: sig_q <= '0;
        OP_LOAD:  sig_q <= seed;
        OP_SHIFT: sig_q <= {sig_q[W-2:0], 1'b0};
        OP_FOLD:  sig_q <= fold_nxt;
        default:  sig_q <= sig_q;
      endcase
    end
  end

  assign sig       = sig_q;
  assign ser_out   = sig_q[W-1];
  assign ser_valid = busy;
  assign match     = (sig_q == golden);

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sig == '0 && !ser_valid));

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load) |=> (sig == $past(seed)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !ser_valid && !unload && !en) |=> $stable(sig));

  // R7
  unload_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && !clr && !load) |=> (sig == {$past(sig[W-2:0]), 1'b0}));

  // R5
  zero_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !ser_valid && !unload && en && !din && sig == '0)
      |=> (sig == W'(1)));
endmodule

// File: tb/full_cycle_sig_bench.sv
`timescale 1ns/1ps
module full_cycle_sig_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0, load = 1'b0, en = 1'b0, din = 1'b0, unload = 1'b0;
  logic [3:0] seed = '0, golden = '0;
  logic [3:0] sig;
  logic       ser_out, ser_valid, match;

  always #2.5 clk = ~clk;

  full_cycle_sig u_full_cycle_sig (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .seed(seed), .en(en),
    .din(din), .unload(unload), .golden(golden), .sig(sig),
    .ser_out(ser_out), .ser_valid(ser_valid), .match(match)
  );

  typedef struct {
    logic [3:0] s;
    logic       so;
    logic       sv;
    logic       mt;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  logic [3:0] m_sig = '0;
  int m_cnt = 0;
  bit done = 0;

  // R5 order from the requirement
  logic [3:0] walk [16] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b1110, 4'b1101,
                           4'b1010, 4'b0101, 4'b1011, 4'b0110, 4'b1100, 4'b1001,
                           4'b0010, 4'b0100, 4'b1000, 4'b0000};

  task automatic step(input logic rs, c, l, input logic [3:0] sd,
                      input logic e, d, u, input logic [3:0] g, input string req);
    exp_t x;
    @(negedge clk);
    rst = rs; clr = c; load = l; seed = sd; en = e; din = d; unload = u; golden = g;
    if (rs || c) begin m_sig = '0; m_cnt = 0; end
    else if (l) begin m_sig = sd; m_cnt = 0; end
    else if (m_cnt != 0) begin m_sig = {m_sig[2:0], 1'b0}; m_cnt--; end
    else if (u) m_cnt = 4;
    else if (e) m_sig = {m_sig[2:0], m_sig[3] ^ m_sig[0] ^ d ^ (m_sig[2:0] == 3'b000)};
    x.s = m_sig; x.so = m_sig[3]; x.sv = (m_cnt != 0); x.mt = (m_sig == g); x.req = req;
    q.push_back(x);
  endtask

  // scoreboard monitor
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        x = q.pop_front();
        checks++;
        if (sig !== x.s || ser_out !== x.so || ser_valid !== x.sv || match !== x.mt) begin
          fails++;
          $display("FAIL %s: sig=%b so=%b sv=%b match=%b expected sig=%b so=%b sv=%b match=%b",
                   x.req, sig, ser_out, ser_valid, match, x.s, x.so, x.sv, x.mt);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset with active inputs
    step(1, 0, 0, 4'h0, 1, 1, 1, 4'h0, "R1");
    step(1, 0, 0, 4'h0, 1, 1, 0, 4'h0, "R1");
    // R5 full zero-input cycle
    for (int i = 0; i < 17; i++) begin
      step(0, 0, 0, 4'h0, 1, 0, 0, 4'hF, "R5");
      checks++;
      if (m_sig !== walk[i % 16]) begin
        fails++;
        $display("FAIL R5: order sig=%b expected %b", m_sig, walk[i % 16]);
      end
    end
    // R8 equality flag
    step(0, 0, 1, 4'b0110, 0, 0, 0, 4'b0110, "R8");
    step(0, 0, 0, 4'h0, 0, 0, 0, 4'b0111, "R8");
    // R4 hold with din toggling
    step(0, 0, 0, 4'h0, 0, 1, 0, 4'h0, "R4");
    step(0, 0, 0, 4'h0, 0, 0, 0, 4'h0, "R4");
    // R6 response folding
    step(0, 0, 0, 4'h0, 1, 1, 0, 4'h0, "R6");
    step(0, 0, 0, 4'h0, 1, 0, 0, 4'h0, "R6");
    step(0, 0, 0, 4'h0, 1, 1, 0, 4'h0, "R6");
    step(0, 0, 0, 4'h0, 1, 1, 0, 4'h0, "R6");
    step(0, 0, 0, 4'h0, 1, 0, 0, 4'h0, "R6");
    step(0, 0, 0, 4'h0, 1, 1, 0, 4'h0, "R6");
    // R3 load beats enable and unload
    step(0, 0, 1, 4'b1010, 1, 1, 1, 4'b1010, "R3");
    // R2 clear beats load
    step(0, 1, 1, 4'b1111, 1, 1, 0, 4'h0, "R2");
    // R7 serial unload of 1011
    step(0, 0, 1, 4'b1011, 0, 0, 0, 4'h0, "R7");
    step(0, 0, 0, 4'h0, 0, 0, 1, 4'h0, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 4'h0, 1, 1, 0, 4'h0, "R7");
    step(0, 0, 0, 4'h0, 0, 0, 0, 4'h0, "R7");
    // R9 repeated requests during unload
    step(0, 0, 1, 4'b1101, 0, 0, 0, 4'h0, "R9");
    step(0, 0, 0, 4'h0, 0, 0, 1, 4'h0, "R9");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 4'h0, 0, 0, 1, 4'h0, "R9");
    // R2 clear aborts an unload
    step(0, 0, 1, 4'b1110, 0, 0, 0, 4'h0, "R2");
    step(0, 0, 0, 4'h0, 0, 0, 1, 4'h0, "R2");
    step(0, 0, 0, 4'h0, 0, 0, 0, 4'h0, "R2");
    step(0, 1, 0, 4'h0, 0, 0, 0, 4'h0, "R2");
    step(0, 0, 0, 4'h0, 0, 0, 0, 4'h0, "R2");
    // R3 load aborts an unload
    step(0, 0, 0, 4'h0, 0, 0, 1, 4'h0, "R3");
    step(0, 0, 1, 4'b0101, 0, 0, 0, 4'b0101, "R3");
    step(0, 0, 0, 4'h0, 0, 0, 0, 4'b0101, "R3");
    step(0, 0, 0, 4'h0, 0, 0, 0, 4'h0, "R1");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule